// File: doc/BRIEF.md
# Four-Pair Stereo Mute and Gain Ramp Controller

This block sits on the sample path behind four stereo sample-rate converters. It decides for each stereo pair whether the pair is muted, moves a per-pair gain toward silence or toward full scale, and scales every sample of the pair by that gain. Pair n carries channels 2n and 2n+1. A pair is muted when its converter reports that it has lost lock, or when software sets the pair's manual mute bit.

By default a mute or unmute is a volume ramp: the gain moves by a fixed step on every accepted sample frame, so the transition has no click. A single shared ramp-off bit makes every gain change abrupt. It also makes the block disregard the manual mute bits, so that with ramp-off set a pair is silenced only by a loss of lock.

Software reaches two 16-bit words through an address/data/write-enable port. Samples arrive as one frame of eight 24-bit channels on a valid/ready stream and leave through a one-deep registered valid/ready stage. An input frame is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

Top module: `pair_mute_ctrl`

## Requirements
- R1: After reset the mute bits and the ramp-off bit are 0, every gain is full scale (32768), `muted` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: Address 0 reads {4'b0, lock_in[3:0], 4'b0, mute[3:0]}, and a write there changes only mute[3:0]. Address 1 reads {15'b0, ramp_off}, and a write there changes only bit 0. Any other address reads 0. Writes to the lock field and to the reserved bits are ignored.
- R3: With ramp-off at 0, a pair's target gain is 0 when its `lock_in` bit is 0 or its mute bit is 1. Otherwise the target is full scale.
- R4: With ramp-off at 0, a pair's gain moves toward its target by 2048 on each accepted input frame, clamped to 0 and 32768. It does not change in cycles without an accepted frame. A ramp from full scale to 0 therefore takes 16 frames.
- R5: When a request changes during a ramp, the gain reverses from its current value. It does not restart from either end.
- R6: With ramp-off at 1, every gain is set to its target on the next clock with no frame needed. The mute bits are ignored, so only `lock_in` at 0 mutes a pair.
- R7: Output channel c equals (sample_c × gain of pair c/2) arithmetically shifted right by 15. The gain used is the one held when the frame is accepted. At full scale the sample passes unchanged.
- R8: `muted[n]` is 1 exactly when pair n's gain is 0.
- R9: `in_ready` = !out_valid || out_ready. An accepted frame appears on `out_data` with `out_valid` one clock later. A stalled output holds its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| lock_in | input | 4 | Per-pair converter lock indication |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame ready |
| in_data | input | 192 | Eight signed 24-bit channels; channel c at bits [24c+23:24c] |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Output frame ready |
| out_data | output | 192 | Eight scaled channels, same packing as the input |
| muted | output | 4 | Per-pair gain-is-zero status |

## Verification
The scaling path is first exercised at full gain with arbitrary samples, which separates a wrong shift or sign handling from a wrong gain. A known sample is then sent right after one ramp step, and the expected reduced value exposes an off-by-one in step size or in which gain is applied. Manual mute, loss of lock and ramp-off are each applied to a different pair, with frames counted, so that a wrong mute decision or ramp length shows as a `muted` transition one frame early or late. Finally, random samples, random back-pressure and random register and lock changes are run against a behavioural model, which tells stall handling and mid-ramp reversal apart from the straight-line cases.

// File: rtl/mute_pkg.sv
`timescale 1ns/1ps
package mute_pkg;
  // Register word layout
  localparam int REG_W     = 16;
  localparam int LOCK_LSB  = 8;
  localparam int FIELD_MAX = 4;

  // Register addresses
  localparam int ADDR_STATUS  = 0;
  localparam int ADDR_RAMPOFF = 1;

  // Direction a gain moves on the next frame
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/mute_regs.sv
`timescale 1ns/1ps
module mute_regs
  import mute_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [NUM_PAIRS-1:0] lock_in,
  output logic [REG_W-1:0]     rdata,
  output logic [NUM_PAIRS-1:0] mute_bits,
  output logic                 ramp_off
);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_RAMPOFF = ADDR_W'(ADDR_RAMPOFF);

  logic [NUM_PAIRS-1:0] mute_q;
  logic                 ramp_off_q;
  logic                 unused_wdata_bits;

  assign unused_wdata_bits = ^wdata[REG_W-1:NUM_PAIRS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q     <= '0;
      ramp_off_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_STATUS)  mute_q     <= wdata[NUM_PAIRS-1:0];
      if (addr == A_RAMPOFF) ramp_off_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_STATUS) begin
      rdata[NUM_PAIRS-1:0]         = mute_q;
      rdata[LOCK_LSB +: NUM_PAIRS] = lock_in;
    end else if (addr == A_RAMPOFF) begin
      rdata[0] = ramp_off_q;
    end
  end

  assign mute_bits = mute_q;
  assign ramp_off  = ramp_off_q;
endmodule

// File: rtl/mute_gain_ramp.sv
`timescale 1ns/1ps
module mute_gain_ramp
  import mute_pkg::*;
#(
  parameter int GAIN_W = 16,
  parameter int STEP   = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              manual_mute,
  input  logic              ramp_off,
  input  logic              strobe,
  output logic [GAIN_W-1:0] gain,
  output logic              muted
);
  localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(1) << (GAIN_W-1);
  localparam logic [GAIN_W-1:0] STEP_G  = GAIN_W'(STEP);
  localparam logic [GAIN_W:0]   UNITY_X = {1'b0, UNITY_G};
  localparam logic [GAIN_W:0]   STEP_X  = {1'b0, STEP_G};

  logic              go_silent;
  ramp_dir_e         dir;
  logic [GAIN_W:0]   up_sum;
  logic [GAIN_W-1:0] gain_nxt;
  logic [GAIN_W-1:0] gain_q;

  // Loss of lock always silences; the manual bit counts only with ramping on
  assign go_silent = !lock || (manual_mute && !ramp_off);

  always_comb begin
    if (go_silent) dir = (gain_q != '0) ? DIR_DOWN : DIR_HOLD;
    else           dir = (gain_q != UNITY_G) ? DIR_UP : DIR_HOLD;
  end

  assign up_sum = {1'b0, gain_q} + STEP_X;

  always_comb begin
    case (dir)
      DIR_DOWN: gain_nxt = (gain_q > STEP_G) ? (gain_q - STEP_G) : '0;
      DIR_UP:   gain_nxt = (up_sum >= UNITY_X) ? UNITY_G : up_sum[GAIN_W-1:0];
      default:  gain_nxt = gain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain_q <= UNITY_G;
    else if (ramp_off) gain_q <= go_silent ? '0 : UNITY_G;
    else if (strobe)   gain_q <= gain_nxt;
  end

  assign gain  = gain_q;
  assign muted = (gain_q == '0);
endmodule

// File: rtl/channel_scaler.sv
`timescale 1ns/1ps
module channel_scaler #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 16
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMPLE_W-1:0] scaled
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam int SHIFT  = GAIN_W - 1;

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod   = $signed(sample) * $signed({1'b0, gain});
    scaled = SAMPLE_W'(prod >>> SHIFT);
  end
endmodule

// File: rtl/pair_mute_ctrl.sv
`timescale 1ns/1ps
module pair_mute_ctrl
  import mute_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int SAMPLE_W  = 24,
  parameter int GAIN_W    = 16,
  parameter int STEP      = 2048,
  parameter int ADDR_W    = 2,
  localparam int NUM_CH   = 2 * NUM_PAIRS,
  localparam int FRAME_W  = NUM_CH * SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_PAIRS-1:0] lock_in,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FRAME_W-1:0]   in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [FRAME_W-1:0]   out_data,
  output logic [NUM_PAIRS-1:0] muted
);
  logic [NUM_PAIRS-1:0] mute_bits;
  logic                 ramp_off;
  logic                 beat;
  logic [GAIN_W-1:0]    pair_gain [NUM_PAIRS];
  logic [FRAME_W-1:0]   scaled_frame;
  logic                 out_valid_q;
  logic [FRAME_W-1:0]   out_data_q;

  mute_regs #(
    .NUM_PAIRS(NUM_PAIRS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .lock_in  (lock_in),
    .rdata    (reg_rdata),
    .mute_bits(mute_bits),
    .ramp_off (ramp_off)
  );

  // One frame per accepted beat; this is the ramp's sample strobe
  assign in_ready = !out_valid_q || out_ready;
  assign beat     = in_valid && in_ready;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    mute_gain_ramp #(
      .GAIN_W(GAIN_W),
      .STEP  (STEP)
    ) u_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock       (lock_in[p]),
      .manual_mute(mute_bits[p]),
      .ramp_off   (ramp_off),
      .strobe     (beat),
      .gain       (pair_gain[p]),
      .muted      (muted[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    channel_scaler #(
      .SAMPLE_W(SAMPLE_W),
      .GAIN_W  (GAIN_W)
    ) u_scale (
      .sample(in_data[c*SAMPLE_W +: SAMPLE_W]),
      .gain  (pair_gain[c/2]),
      .scaled(scaled_frame[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (beat) begin
      out_valid_q <= 1'b1;
      out_data_q  <= scaled_frame;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/pair_mute_ctrl_checker.sv
`timescale 1ns/1ps
module pair_mute_ctrl_checker #(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 2,
  parameter int FRAME_W   = 192
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [15:0]          reg_wdata,
  input logic [15:0]          reg_rdata,
  input logic [NUM_PAIRS-1:0] lock_in,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [FRAME_W-1:0]   out_data,
  input logic [NUM_PAIRS-1:0] muted,
  input logic                 ramp_off
);
  // R9: a stalled output keeps valid and data
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: an accepted frame shows up as valid output on the next clock
  a_r9_beat_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2: a mute write reads back on the next cycle at the same address
  a_r2_mute_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0) |=>
      (reg_addr != '0 || reg_rdata[NUM_PAIRS-1:0] == $past(reg_wdata[NUM_PAIRS-1:0])));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
    // R6: with ramp-off, loss of lock silences on the next clock
    a_r6_abrupt_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_off && !lock_in[p]) |=> muted[p]);

    // R6: with ramp-off, a locked pair is at full gain whatever its mute bit
    a_r6_manual_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_off && lock_in[p]) |=> !muted[p]);

    // R4: without an accepted frame a ramping gain does not move
    a_r4_no_frame_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ramp_off && !(in_valid && in_ready)) |=> $stable(muted[p]));
  end
endmodule

bind pair_mute_ctrl pair_mute_ctrl_checker #(
  .NUM_PAIRS(NUM_PAIRS),
  .ADDR_W   (ADDR_W),
  .FRAME_W  (FRAME_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .lock_in  (lock_in),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .muted    (muted),
  .ramp_off (ramp_off)
);

// File: tb/pair_mute_ctrl_tb.sv
`timescale 1ns/1ps
module pair_mute_ctrl_tb;
  localparam int NP = 4;
  localparam int SW = 24;
  localparam int NC = 8;
  localparam int FW = NC * SW;
  localparam int FULL = 32768;
  localparam int STEPV = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [NP-1:0] lock_in = '1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [FW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [FW-1:0] out_data;
  logic [NP-1:0] muted;

  int  checks = 0;
  int  fails = 0;
  bit  rand_ready = 1'b0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  pair_mute_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_in(lock_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .muted(muted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] scale(input logic signed [SW-1:0] s, input int g);
    longint p;
    p = longint'(s) * longint'(g);
    p = p >>> 15;
    return p[SW-1:0];
  endfunction

  // ---------------- behavioural reference model ----------------
  int            gm [NP];
  logic [NP-1:0] mute_m;
  logic          roff_m;
  logic          ov_m;
  logic [FW-1:0] od_m;

  always begin
    @(posedge clk);
    if (!rst_n) begin
      for (int n = 0; n < NP; n++) gm[n] = FULL;
      mute_m = '0; roff_m = 1'b0; ov_m = 1'b0; od_m = '0;
    end else begin
      bit acc;
      acc = in_valid && (!ov_m || out_ready);
      if (acc) begin
        for (int c = 0; c < NC; c++) od_m[c*SW +: SW] = scale(in_data[c*SW +: SW], gm[c/2]);
        ov_m = 1'b1;
      end else if (out_ready) ov_m = 1'b0;
      for (int n = 0; n < NP; n++) begin
        bit silent;
        silent = !lock_in[n] || (mute_m[n] && !roff_m);
        if (roff_m) gm[n] = silent ? 0 : FULL;
        else if (acc) gm[n] = silent ? ((gm[n] > STEPV) ? gm[n] - STEPV : 0)
                                     : ((gm[n] + STEPV >= FULL) ? FULL : gm[n] + STEPV);
      end
      if (reg_wr && reg_addr == 2'd0) mute_m = reg_wdata[NP-1:0];
      if (reg_wr && reg_addr == 2'd1) roff_m = reg_wdata[0];
    end
    #1;
    begin
      logic [15:0]   exp_rd;
      logic [NP-1:0] exp_mu;
      exp_rd = '0;
      if (reg_addr == 2'd0) exp_rd = {4'b0, lock_in, 4'b0, mute_m};
      else if (reg_addr == 2'd1) exp_rd = {15'b0, roff_m};
      for (int n = 0; n < NP; n++) exp_mu[n] = (gm[n] == 0);
      chk(reg_rdata == exp_rd, "R2", "reg_rdata", reg_rdata, exp_rd);
      chk(muted == exp_mu, "R8", "muted", muted, exp_mu);
      chk(out_valid == ov_m, "R9", "out_valid", out_valid, ov_m);
      chk(in_ready == (!ov_m || out_ready), "R9", "in_ready", in_ready, (!ov_m || out_ready));
      if (ov_m) for (int c = 0; c < NC; c++)
        chk(out_data[c*SW +: SW] == od_m[c*SW +: SW], "R7", "out_data channel",
            out_data[c*SW +: SW], od_m[c*SW +: SW]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata == e, req, "register read", reg_rdata, e);
  endtask

  task automatic send(input logic [FW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [FW-1:0] rand_frame();
    logic [FW-1:0] f;
    for (int c = 0; c < NC; c++) f[c*SW +: SW] = SW'($urandom);
    return f;
  endfunction

  always @(negedge clk) if (rand_ready) out_ready = ($urandom_range(0, 9) < 7);

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(muted == '0, "R1", "muted after reset", muted, 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    rd_chk(2'd0, 16'h0F00, "R1");
    rd_chk(2'd1, 16'h0000, "R1");

    // R2: reserved and lock bits ignored on write, reserved read 0
    wr(2'd0, 16'hF0F0);
    rd_chk(2'd0, 16'h0F00, "R2");
    wr(2'd1, 16'hFFFE);
    rd_chk(2'd1, 16'h0000, "R2");
    wr(2'd2, 16'hFFFF);
    rd_chk(2'd2, 16'h0000, "R2");

    // R7: full scale passes samples through
    for (int i = 0; i < 4; i++) begin
      f = rand_frame();
      send(f);
      chk(out_data == f, "R7", "full-scale passthrough", out_data[SW-1:0], f[SW-1:0]);
    end

    // R4/R3: manual mute on pair 0 ramps over 16 frames
    wr(2'd0, 16'h0001);
    send(rand_frame());
    f = rand_frame(); f[SW-1:0] = 24'h100000;
    send(f);
    chk(out_data[SW-1:0] == 24'h0F0000, "R4", "one step below full", out_data[SW-1:0], 24'h0F0000);
    for (int i = 0; i < 13; i++) send(rand_frame());
    chk(muted[0] == 1'b0, "R4", "pair0 after 15 frames", muted[0], 0);
    send(rand_frame());
    chk(muted[0] == 1'b1, "R3", "pair0 after 16 frames", muted[0], 1);
    repeat (10) @(negedge clk);
    chk(muted[0] == 1'b1, "R4", "pair0 idle holds", muted[0], 1);

    // R5: pair 1 reverses mid-ramp
    wr(2'd0, 16'h0003);
    for (int i = 0; i < 4; i++) send(rand_frame());
    wr(2'd0, 16'h0001);
    for (int i = 0; i < 4; i++) send(rand_frame());
    f = rand_frame(); f[2*SW +: SW] = 24'h923456;
    send(f);
    chk(out_data[2*SW +: SW] == 24'h923456, "R5", "pair1 back at full after reversal",
        out_data[2*SW +: SW], 24'h923456);

    // R9: stall holds output
    f = out_data;
    @(negedge clk); out_ready = 1'b0;
    send(rand_frame());
    f = out_data;
    repeat (3) @(negedge clk);
    #1 chk(out_valid && !in_ready && out_data == f, "R9", "stall holds data", out_data[SW-1:0], f[SW-1:0]);
    @(negedge clk); out_ready = 1'b1;

    // R3: loss of lock on pair 2 mutes without a mute bit
    @(negedge clk); lock_in = 4'b1011;
    rd_chk(2'd0, 16'h0B01, "R2");
    for (int i = 0; i < 15; i++) send(rand_frame());
    chk(muted[2] == 1'b0, "R3", "pair2 after 15 frames", muted[2], 0);
    send(rand_frame());
    chk(muted[2] == 1'b1, "R3", "pair2 unlocked muted", muted[2], 1);

    // R6: ramp-off makes changes abrupt and drops the manual mute
    wr(2'd1, 16'h0001);
    @(negedge clk); #1;
    chk(muted[0] == 1'b0, "R6", "manual mute ignored", muted[0], 0);
    chk(muted[2] == 1'b1, "R6", "unlocked pair stays muted", muted[2], 1);
    @(negedge clk); lock_in = 4'b0011;
    @(negedge clk); #1;
    chk(muted[3] == 1'b1, "R6", "abrupt mute on unlock", muted[3], 1);
    @(negedge clk); lock_in = 4'b1111;
    @(negedge clk); #1;
    chk(muted == 4'b0000, "R6", "abrupt unmute on relock", muted, 0);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0000);

    // Random traffic against the model
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0) wr(2'($urandom_range(0, 1) == 0 ? 0 : 1),
                                         16'($urandom) & (($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'hFFFE));
      if ($urandom_range(0, 19) == 0) begin @(negedge clk); lock_in = NP'($urandom); end
      if ($urandom_range(0, 3) == 0) begin @(negedge clk); reg_addr = 2'($urandom); end
      send(rand_frame());
    end
    rand_ready = 1'b0;
    @(negedge clk); out_ready = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule